// File: doc/BRIEF.md
# Function Unit Issue and Operand Handshake Controller

This block steers a single instruction through one function unit. An issue pulse claims the idle unit and captures the opcode. The unit then raises one read request per source operand. Each request stays up until its own grant pulse arrives, and the operand word on the matching bus lane is captured in that same cycle.

Once every operand is in hand, the unit raises a write request and computes the result with a small combinational ALU. The result appears on the output bus only while the write grant is accepted. A shadow input holds the write request in place until it is released. A kill input cancels whatever the unit still has pending and returns it to idle.

Top module: `fu_issue_ctl`

## Requirements
- R1: After synchronous reset, busy_o, every rd_req_o bit and wr_req_o are low, result_o is zero, and the captured operands are cleared.
- R2: An issue_i pulse seen while idle sets busy_o and every rd_req_o bit on the next cycle, and captures op_i as the opcode.
- R3: An issue_i pulse seen while busy_o is high has no effect: no read request rises again, and the captured opcode is kept.
- R4: No rd_req_o bit and no wr_req_o is ever high unless an issue has been accepted since reset.
- R5: An rd_req_o bit never falls unless its own rd_gnt_i bit or kill_i was high in the cycle before. A grant on a bit whose request is low is ignored and leaves the captured operand unchanged.
- R6: A grant on a requesting bit clears only that rd_req_o bit on the next cycle. In the grant cycle it captures the matching lane of src_data_i: operand A is bits [15:0] and operand B is bits [31:16].
- R7: kill_i while reads are pending clears every rd_req_o bit and busy_o on the next cycle, and no write request follows.
- R8: wr_req_o rises one cycle after the last rd_req_o bit has fallen (two cycles after the last read grant), provided kill_i is low in between.
- R9: wr_gnt_i with wr_req_o high and shadow_i low clears wr_req_o and busy_o on the next cycle.
- R10: While shadow_i is high, wr_req_o and busy_o do not fall; both write grant and kill are ignored. After shadow_i drops, a write grant completes normally.
- R11: kill_i with wr_req_o high and shadow_i low clears wr_req_o and busy_o on the next cycle.
- R12: result_o equals op(A,B) modulo 2^16 in each cycle where wr_gnt_i, wr_req_o are high and shadow_i is low, and is zero otherwise. The opcode codes are 0 for A+B, 1 for A-B, 2 for A AND B, and 3 for A XOR B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue pulse claiming the unit |
| op_i | input | 2 | Opcode, captured at issue |
| busy_o | output | 1 | Unit holds an instruction |
| rd_req_o | output | 2 | Per-operand read request |
| rd_gnt_i | input | 2 | Per-operand read grant pulse |
| src_data_i | input | 32 | Operand lanes, A in [15:0], B in [31:16] |
| wr_req_o | output | 1 | Result write-back request |
| wr_gnt_i | input | 1 | Write grant pulse |
| shadow_i | input | 1 | Shadow hold blocking write completion |
| kill_i | input | 1 | Cancel pending requests |
| result_o | output | 16 | ALU result, driven during accepted write grant |

## Verification
Operands are granted in three patterns: both in one cycle, A before B with idle gaps, and B before A. This separates per-bit clearing from a shared clear and shows when write-back starts relative to the last grant. The operand lanes carry junk outside grant cycles, so an operand captured at the wrong time shows up as a wrong result. Each opcode is used at least once. The bench also tries kill in the read phase and in the write phase, a write grant and a kill during shadow hold, a re-issue while busy, and a grant on a bit that is already cleared. These patterns separate each cancel or hold path from normal completion.

// File: rtl/fu_pkg.sv
package fu_pkg;

    localparam int unsigned FU_DW   = 16;
    localparam int unsigned FU_NSRC = 2;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } fu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } fu_state_e;

    function automatic logic is_idle(fu_state_e s);
        return s == ST_IDLE;
    endfunction

endpackage

// File: rtl/fu_rd_slot.sv
module fu_rd_slot #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm_i,
    input  logic         gnt_i,
    input  logic         kill_i,
    input  logic [W-1:0] din_i,
    output logic         req_o,
    output logic [W-1:0] dout_o
);
    logic         req_q;
    logic [W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            val_q <= '0;
        end else if (arm_i) begin
            req_q <= 1'b1;
        end else if (req_q) begin
            if (kill_i) begin
                req_q <= 1'b0;
            end else if (gnt_i) begin
                req_q <= 1'b0;
                val_q <= din_i;
            end
        end
    end

    assign req_o  = req_q;
    assign dout_o = val_q;
endmodule

// File: rtl/fu_seq.sv
module fu_seq
    import fu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    input  logic rd_pend_i,
    input  logic kill_i,
    input  logic wr_gnt_i,
    input  logic shadow_i,
    output logic start_o,
    output logic busy_o,
    output logic wr_req_o
);
    fu_state_e state_q;
    logic      wr_q;

    assign start_o = issue_i && is_idle(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_o) state_q <= ST_READ;
                end
                ST_READ: begin
                    if (kill_i) begin
                        state_q <= ST_IDLE;
                    end else if (!rd_pend_i) begin
                        state_q <= ST_WRITE;
                        wr_q    <= 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (!shadow_i && (kill_i || wr_gnt_i)) begin
                        state_q <= ST_IDLE;
                        wr_q    <= 1'b0;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    wr_q    <= 1'b0;
                end
            endcase
        end
    end

    assign busy_o   = !is_idle(state_q);
    assign wr_req_o = wr_q;
endmodule

// File: rtl/fu_alu.sv
module fu_alu
    import fu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  fu_op_e       op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/fu_issue_ctl.sv
module fu_issue_ctl
    import fu_pkg::*;
#(
    parameter int unsigned DATA_W = FU_DW,
    parameter int unsigned NSRC   = FU_NSRC
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   issue_i,
    input  logic [1:0]             op_i,
    output logic                   busy_o,
    output logic [NSRC-1:0]        rd_req_o,
    input  logic [NSRC-1:0]        rd_gnt_i,
    input  logic [NSRC*DATA_W-1:0] src_data_i,
    output logic                   wr_req_o,
    input  logic                   wr_gnt_i,
    input  logic                   shadow_i,
    input  logic                   kill_i,
    output logic [DATA_W-1:0]      result_o
);
    localparam int unsigned LANES = NSRC;

    logic              start;
    logic              rd_pend;
    fu_op_e            op_q;
    logic [DATA_W-1:0] opnd [LANES];
    logic [DATA_W-1:0] alu_y;

    for (genvar i = 0; i < LANES; i++) begin : g_slot
        fu_rd_slot #(.W(DATA_W)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .arm_i  (start),
            .gnt_i  (rd_gnt_i[i]),
            .kill_i (kill_i),
            .din_i  (src_data_i[i*DATA_W +: DATA_W]),
            .req_o  (rd_req_o[i]),
            .dout_o (opnd[i])
        );
    end

    assign rd_pend = |rd_req_o;

    fu_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .issue_i   (issue_i),
        .rd_pend_i (rd_pend),
        .kill_i    (kill_i),
        .wr_gnt_i  (wr_gnt_i),
        .shadow_i  (shadow_i),
        .start_o   (start),
        .busy_o    (busy_o),
        .wr_req_o  (wr_req_o)
    );

    always_ff @(posedge clk) begin
        if (rst) op_q <= OP_ADD;
        else if (start) op_q <= fu_op_e'(op_i);
    end

    fu_alu #(.W(DATA_W)) u_alu (
        .op_i (op_q),
        .a_i  (opnd[0]),
        .b_i  (opnd[LANES-1]),
        .y_o  (alu_y)
    );

    assign result_o = (wr_gnt_i && wr_req_o && !shadow_i) ? alu_y : '0;
endmodule

// File: rtl/fu_issue_ctl_chk.sv
module fu_issue_ctl_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned NSRC   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_i,
    input logic              busy_o,
    input logic [NSRC-1:0]   rd_req_o,
    input logic [NSRC-1:0]   rd_gnt_i,
    input logic              wr_req_o,
    input logic              wr_gnt_i,
    input logic              shadow_i,
    input logic              kill_i,
    input logic [DATA_W-1:0] result_o
);
    logic seen_issue;
    always_ff @(posedge clk) begin
        if (rst) seen_issue <= 1'b0;
        else if (issue_i) seen_issue <= 1'b1;
    end

    assert_busy_after_issue_R2: assert property (@(posedge clk) disable iff (rst)
        issue_i && !busy_o |=> busy_o && (&rd_req_o));

    assert_no_rearm_R3: assert property (@(posedge clk) disable iff (rst)
        busy_o && issue_i |=> (rd_req_o & ~$past(rd_req_o)) == '0);

    assert_no_req_before_issue_R4: assert property (@(posedge clk) disable iff (rst)
        ((|rd_req_o) || wr_req_o) |-> seen_issue);

    for (genvar i = 0; i < NSRC; i++) begin : g_rd
        assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
            rd_req_o[i] && !rd_gnt_i[i] && !kill_i |=> rd_req_o[i]);
        assert_rd_clear_R6: assert property (@(posedge clk) disable iff (rst)
            rd_req_o[i] && rd_gnt_i[i] |=> !rd_req_o[i]);
    end

    assert_kill_reads_R7: assert property (@(posedge clk) disable iff (rst)
        (|rd_req_o) && kill_i |=> rd_req_o == '0 && !busy_o);

    assert_wr_start_R8: assert property (@(posedge clk) disable iff (rst)
        busy_o && rd_req_o == '0 && !wr_req_o && !kill_i |=> wr_req_o);

    assert_wr_done_R9: assert property (@(posedge clk) disable iff (rst)
        wr_req_o && wr_gnt_i && !shadow_i |=> !wr_req_o && !busy_o);

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (rst)
        wr_req_o && shadow_i |=> wr_req_o && busy_o);

    assert_kill_write_R11: assert property (@(posedge clk) disable iff (rst)
        wr_req_o && kill_i && !shadow_i |=> !wr_req_o);

    assert_result_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !(wr_gnt_i && wr_req_o && !shadow_i) |-> result_o == '0);
endmodule

bind fu_issue_ctl fu_issue_ctl_chk #(.DATA_W(DATA_W), .NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .issue_i  (issue_i),
    .busy_o   (busy_o),
    .rd_req_o (rd_req_o),
    .rd_gnt_i (rd_gnt_i),
    .wr_req_o (wr_req_o),
    .wr_gnt_i (wr_gnt_i),
    .shadow_i (shadow_i),
    .kill_i   (kill_i),
    .result_o (result_o)
);

// File: tb/sim_fu_issue_ctl.sv
module sim_fu_issue_ctl;
    localparam int CLK_P = 10;
    localparam logic [15:0] JUNK_A = 16'hDEAD;
    localparam logic [15:0] JUNK_B = 16'hBEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        busy;
    logic [1:0]  rd_req;
    logic [1:0]  rd_gnt = 2'b00;
    logic [31:0] src = {JUNK_B, JUNK_A};
    logic        wr_req;
    logic        wr_gnt = 1'b0;
    logic        shadow = 1'b0;
    logic        kill = 1'b0;
    logic [15:0] result;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] expq [$];

    always #(CLK_P/2) clk = ~clk;

    fu_issue_ctl u0 (
        .clk(clk), .rst(rst), .issue_i(issue), .op_i(op), .busy_o(busy),
        .rd_req_o(rd_req), .rd_gnt_i(rd_gnt), .src_data_i(src),
        .wr_req_o(wr_req), .wr_gnt_i(wr_gnt), .shadow_i(shadow),
        .kill_i(kill), .result_o(result)
    );

    function automatic logic [15:0] ref_alu(logic [1:0] o, logic [15:0] a, logic [15:0] b);
        case (o)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: compares every accepted write-back against the scoreboard (R12)
    always @(posedge clk) begin
        if (!rst && wr_gnt && wr_req && !shadow) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R12 unexpected result", {16'h0, result}, 32'h0);
            end else begin
                logic [15:0] e;
                e = expq.pop_front();
                chk(result == e, "R12 result", {16'h0, result}, {16'h0, e});
            end
        end
    end

    task automatic do_issue(logic [1:0] o);
        issue = 1'b1; op = o;
        step();
        issue = 1'b0; op = ~o;
        chk(busy == 1'b1, "R2 busy", {31'h0, busy}, 32'h1);
        chk(rd_req == 2'b11, "R2 rd_req", {30'h0, rd_req}, 32'h3);
    endtask

    task automatic grant(logic [1:0] g, logic [15:0] a, logic [15:0] b);
        rd_gnt = g; src = {b, a};
        step();
        rd_gnt = 2'b00; src = {JUNK_B, JUNK_A};
    endtask

    task automatic wait_write();
        chk(wr_req == 1'b0, "R8 wr_req not yet", {31'h0, wr_req}, 32'h0);
        step();
        chk(wr_req == 1'b1, "R8 wr_req rises", {31'h0, wr_req}, 32'h1);
    endtask

    task automatic complete(logic [15:0] e);
        expq.push_back(e);
        wr_gnt = 1'b1;
        step();
        wr_gnt = 1'b0;
        chk(wr_req == 1'b0, "R9 wr_req clears", {31'h0, wr_req}, 32'h0);
        chk(busy == 1'b0, "R9 busy clears", {31'h0, busy}, 32'h0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", {31'h0, busy}, 32'h0);
        chk(rd_req == 2'b00, "R1 rd_req", {30'h0, rd_req}, 32'h0);
        chk(wr_req == 1'b0, "R1 wr_req", {31'h0, wr_req}, 32'h0);
        chk(result == 16'h0, "R1 result", {16'h0, result}, 32'h0);

        // R4 grants without issue raise nothing
        rd_gnt = 2'b11; wr_gnt = 1'b1;
        step();
        rd_gnt = 2'b00;
        chk(rd_req == 2'b00, "R4 rd_req", {30'h0, rd_req}, 32'h0);
        chk(wr_req == 1'b0, "R4 wr_req", {31'h0, wr_req}, 32'h0);
        chk(result == 16'h0, "R12 idle result", {16'h0, result}, 32'h0);
        wr_gnt = 1'b0;

        // Pattern 1: both operands granted together, ADD
        do_issue(2'd0);
        grant(2'b11, 16'h1234, 16'hF00F);
        chk(rd_req == 2'b00, "R6 both clear", {30'h0, rd_req}, 32'h0);
        wait_write();
        complete(ref_alu(2'd0, 16'h1234, 16'hF00F));

        // Pattern 2: A then B with gaps, SUB, re-issue while busy (R3)
        do_issue(2'd1);
        grant(2'b01, 16'h0005, 16'h0);
        chk(rd_req == 2'b10, "R6 only A clears", {30'h0, rd_req}, 32'h2);
        issue = 1'b1; op = 2'd3;
        step();
        issue = 1'b0;
        chk(rd_req == 2'b10, "R3 no rearm", {30'h0, rd_req}, 32'h2);
        step();
        chk(rd_req == 2'b10, "R5 B held", {30'h0, rd_req}, 32'h2);
        grant(2'b01, 16'h7777, 16'h0);   // grant on cleared bit: ignored (R5)
        chk(rd_req == 2'b10, "R5 stale grant", {30'h0, rd_req}, 32'h2);
        grant(2'b10, 16'h0, 16'h0009);
        chk(rd_req == 2'b00, "R6 B clears", {30'h0, rd_req}, 32'h0);
        wait_write();
        complete(ref_alu(2'd1, 16'h0005, 16'h0009));

        // Pattern 3: B then A, AND
        do_issue(2'd2);
        grant(2'b10, 16'h0, 16'h0FF0);
        chk(rd_req == 2'b01, "R6 only B clears", {30'h0, rd_req}, 32'h1);
        grant(2'b01, 16'h3C3C, 16'h0);
        wait_write();
        complete(ref_alu(2'd2, 16'h3C3C, 16'h0FF0));

        // Kill during read phase (R7)
        do_issue(2'd3);
        grant(2'b01, 16'hAAAA, 16'h0);
        kill = 1'b1;
        step();
        kill = 1'b0;
        chk(rd_req == 2'b00, "R7 reads cleared", {30'h0, rd_req}, 32'h0);
        chk(busy == 1'b0, "R7 busy cleared", {31'h0, busy}, 32'h0);
        step(); step();
        chk(wr_req == 1'b0, "R7 no write", {31'h0, wr_req}, 32'h0);

        // Shadow hold (R10), then XOR completes
        do_issue(2'd3);
        grant(2'b11, 16'h5A5A, 16'h00FF);
        wait_write();
        shadow = 1'b1; wr_gnt = 1'b1; kill = 1'b1;
        #1;
        chk(result == 16'h0, "R12 shadow result", {16'h0, result}, 32'h0);
        step();
        kill = 1'b0; wr_gnt = 1'b0;
        chk(wr_req == 1'b1, "R10 wr_req held", {31'h0, wr_req}, 32'h1);
        chk(busy == 1'b1, "R10 busy held", {31'h0, busy}, 32'h1);
        shadow = 1'b0;
        complete(ref_alu(2'd3, 16'h5A5A, 16'h00FF));

        // Kill during write phase (R11)
        do_issue(2'd0);
        grant(2'b11, 16'h0001, 16'h0002);
        wait_write();
        kill = 1'b1;
        step();
        kill = 1'b0;
        chk(wr_req == 1'b0, "R11 wr_req cleared", {31'h0, wr_req}, 32'h0);
        chk(busy == 1'b0, "R11 busy cleared", {31'h0, busy}, 32'h0);

        // Unit is reusable after kill: ADD with wrap-around
        do_issue(2'd0);
        grant(2'b11, 16'hFFFF, 16'h0003);
        wait_write();
        complete(ref_alu(2'd0, 16'hFFFF, 16'h0003));

        step();
        chk(expq.size() == 0, "R12 scoreboard drained", expq.size(), 32'h0);
        finish_run();
    end
endmodule